// File: doc/BRIEF.md
# Single-Wire Debug Host Bit Engine

This block is the host end of a single-wire debug link, reduced to one bit at a time. It runs on a clock whose cycles match the target's clock and shapes the waveform on the shared open-drain line. Every bit starts with the host pulling the line low. A transmitted 1 is a short low pulse followed by one cycle of active high drive. A transmitted 0 is a long low pulse followed by one cycle of active high drive. A received bit is a short low pulse, then the host releases the line and reads back the level the target leaves on it.

A controller above this block raises `start_i` with the direction and the bit value, then waits for `done_o`. The block does not assemble bytes or sequence commands. The low lengths, release points and sample point are placed so that they fall inside the target's windows. A 1 is driven high well before the target's glitch limit at cycle 8. A 0 stays low past the target's sampling point at cycle 10. In a receive bit the line is released before the target's own speedup pulse at cycle 7.

Top module: `dbg_host_bit`

## Requirements
- R1: While reset is high and in the first cycle after it, `line_oe_o`, `line_drv_o`, `done_o` and `rx_bit_o` are all 0.
- R2: A start is accepted on a rising edge where `start_i` is 1 and no bit is active. Call the cycle after that edge bit cycle 0. The bit occupies cycles 0 to 15, and in cycle 0 the line is driven low (`line_oe_o`=1, `line_drv_o`=0). Whenever `line_drv_o` is 1, `line_oe_o` is also 1.
- R3: A transmitted 1 (`rx_mode_i`=0, `tx_bit_i`=1) drives low in cycles 0 to 3 and drives high in cycle 4. The line is released (`line_oe_o`=0) in cycles 5 to 15.
- R4: A transmitted 0 (`rx_mode_i`=0, `tx_bit_i`=0) drives low in cycles 0 to 12 and drives high in cycle 13. The line is released in cycles 14 and 15.
- R5: A receive bit (`rx_mode_i`=1) drives low in cycles 0 and 1 and releases the line in cycles 2 to 15. It never drives high.
- R6: `rx_bit_o` takes the level of `line_i` during bit cycle 10. It shows that value from cycle 11 on, including the `done_o` cycle, and holds it until the next bit's cycle 10.
- R7: `done_o` is 1 in bit cycle 15 only, exactly once per bit.
- R8: `start_i` raised in bit cycles 0 to 14 is ignored. The current waveform continues unchanged, and no extra bit follows.
- R9: `start_i` raised in bit cycle 15 starts a new bit in the next cycle, so back-to-back bits are 16 cycles apart.
- R10: `rx_mode_i` and `tx_bit_i` are read only on the accepting edge. Changing them during a bit does not alter its waveform.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one cycle per target clock cycle |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to run one bit |
| rx_mode_i | input | 1 | 1 = receive bit, 0 = transmit bit |
| tx_bit_i | input | 1 | Value to transmit when `rx_mode_i` is 0 |
| line_i | input | 1 | Level read back from the line |
| line_oe_o | output | 1 | 1 = host drives the line |
| line_drv_o | output | 1 | Level driven while `line_oe_o` is 1 |
| done_o | output | 1 | One-cycle pulse in the last cycle of a bit |
| rx_bit_o | output | 1 | Level sampled in bit cycle 10 |

## Verification
A wrong phase count or a lost bit kind shows up on the drive pins in the very cycle it goes wrong. The release edge or the speedup pulse moves by a cycle, or it appears for the wrong kind. The bench compares both drive pins against the expected value in every cycle of every bit. A sampler that picks the wrong cycle shows only at `done_o`. For that reason the bench makes `line_i` carry the wanted value in cycle 10 alone and the opposite value in all other cycles. A start that is wrongly accepted mid-bit bends the waveform at once, and a second bit that should not start shows as drive activity in the idle cycles that follow.

// File: rtl/dbg_host_pkg.sv
package dbg_host_pkg;

    typedef enum logic [1:0] {
        KIND_RX  = 2'd0,
        KIND_TX0 = 2'd1,
        KIND_TX1 = 2'd2
    } bit_kind_e;

    typedef struct packed {
        logic oe;
        logic val;
    } line_drive_t;

    localparam int unsigned DEF_BIT_LEN   = 16;
    localparam int unsigned DEF_LOW_ONE   = 4;
    localparam int unsigned DEF_LOW_ZERO  = 13;
    localparam int unsigned DEF_LOW_RX    = 2;
    localparam int unsigned DEF_SAMPLE_AT = 10;

    function automatic bit_kind_e kind_of(input logic rx, input logic txb);
        if (rx)
            return KIND_RX;
        else if (txb)
            return KIND_TX1;
        else
            return KIND_TX0;
    endfunction

endpackage

// File: rtl/dbg_bit_timer.sv
module dbg_bit_timer
    import dbg_host_pkg::*;
#(
    parameter int unsigned BIT_LEN = DEF_BIT_LEN,
    parameter int unsigned CW      = $clog2(BIT_LEN)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          rx_i,
    input  logic          txb_i,
    output logic          active_o,
    output logic [CW-1:0] cnt_o,
    output bit_kind_e     kind_o,
    output logic          accept_o,
    output logic          last_o
);

    localparam logic [CW-1:0] LAST = CW'(BIT_LEN - 1);

    logic          active_q;
    logic [CW-1:0] cnt_q;
    bit_kind_e     kind_q;

    assign last_o   = active_q && (cnt_q == LAST);
    assign accept_o = start_i && (!active_q || last_o);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            kind_q   <= KIND_RX;
        end else if (accept_o) begin
            active_q <= 1'b1;
            cnt_q    <= '0;
            kind_q   <= kind_of(rx_i, txb_i);
        end else if (active_q) begin
            if (last_o) begin
                active_q <= 1'b0;
                cnt_q    <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign active_o = active_q;
    assign cnt_o    = cnt_q;
    assign kind_o   = kind_q;

    // R8 / R10: kind cannot change in mid-bit
    a_r10_kind_held: assert property (@(posedge clk) disable iff (rst)
        (active_q && !last_o) |=> (kind_q == $past(kind_q)));

    // R8: a mid-bit start does not restart the count
    a_r8_count_advances: assert property (@(posedge clk) disable iff (rst)
        (active_q && !last_o) |=> (active_q && cnt_q == $past(cnt_q) + 1'b1));

    // R7
    a_r7_single_done: assert property (@(posedge clk) disable iff (rst)
        last_o |=> !last_o);

endmodule

// File: rtl/dbg_line_shaper.sv
module dbg_line_shaper
    import dbg_host_pkg::*;
#(
    parameter int unsigned CW       = 4,
    parameter int unsigned LOW_ONE  = DEF_LOW_ONE,
    parameter int unsigned LOW_ZERO = DEF_LOW_ZERO,
    parameter int unsigned LOW_RX   = DEF_LOW_RX
) (
    input  logic          active_i,
    input  logic [CW-1:0] cnt_i,
    input  bit_kind_e     kind_i,
    output line_drive_t   drive_o
);

    localparam logic [CW-1:0] L1 = CW'(LOW_ONE);
    localparam logic [CW-1:0] L0 = CW'(LOW_ZERO);
    localparam logic [CW-1:0] LR = CW'(LOW_RX);

    logic [CW-1:0] low_len;
    logic          is_tx;

    always_comb begin
        unique case (kind_i)
            KIND_TX1: low_len = L1;
            KIND_TX0: low_len = L0;
            default:  low_len = LR;
        endcase
        is_tx       = (kind_i != KIND_RX);
        drive_o.val = active_i && is_tx && (cnt_i == low_len);
        drive_o.oe  = active_i && ((cnt_i < low_len) || (is_tx && cnt_i == low_len));
    end

endmodule

// File: rtl/dbg_bit_sampler.sv
module dbg_bit_sampler #(
    parameter int unsigned CW        = 4,
    parameter int unsigned SAMPLE_AT = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active_i,
    input  logic [CW-1:0] cnt_i,
    input  logic          line_i,
    output logic          bit_o
);

    localparam logic [CW-1:0] SAT = CW'(SAMPLE_AT);

    logic take;
    logic bit_q;

    assign take = active_i && (cnt_i == SAT);

    always_ff @(posedge clk) begin
        if (rst)
            bit_q <= 1'b0;
        else if (take)
            bit_q <= line_i;
    end

    assign bit_o = bit_q;

    // R6: the sample changes only at the sample point
    a_r6_hold_between: assert property (@(posedge clk) disable iff (rst)
        !take |=> (bit_q == $past(bit_q)));

endmodule

// File: rtl/dbg_host_bit.sv
module dbg_host_bit
    import dbg_host_pkg::*;
#(
    parameter int unsigned BIT_LEN   = DEF_BIT_LEN,
    parameter int unsigned LOW_ONE   = DEF_LOW_ONE,
    parameter int unsigned LOW_ZERO  = DEF_LOW_ZERO,
    parameter int unsigned LOW_RX    = DEF_LOW_RX,
    parameter int unsigned SAMPLE_AT = DEF_SAMPLE_AT
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic rx_mode_i,
    input  logic tx_bit_i,
    input  logic line_i,
    output logic line_oe_o,
    output logic line_drv_o,
    output logic done_o,
    output logic rx_bit_o
);

    localparam int unsigned CW = $clog2(BIT_LEN);

    logic          active;
    logic [CW-1:0] cnt;
    bit_kind_e     kind;
    logic          accept;
    logic          last;
    line_drive_t   drive;

    dbg_bit_timer #(.BIT_LEN(BIT_LEN), .CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .rx_i     (rx_mode_i),
        .txb_i    (tx_bit_i),
        .active_o (active),
        .cnt_o    (cnt),
        .kind_o   (kind),
        .accept_o (accept),
        .last_o   (last)
    );

    dbg_line_shaper #(
        .CW(CW), .LOW_ONE(LOW_ONE), .LOW_ZERO(LOW_ZERO), .LOW_RX(LOW_RX)
    ) u_shaper (
        .active_i (active),
        .cnt_i    (cnt),
        .kind_i   (kind),
        .drive_o  (drive)
    );

    dbg_bit_sampler #(.CW(CW), .SAMPLE_AT(SAMPLE_AT)) u_sampler (
        .clk      (clk),
        .rst      (rst),
        .active_i (active),
        .cnt_i    (cnt),
        .line_i   (line_i),
        .bit_o    (rx_bit_o)
    );

    assign line_oe_o  = drive.oe;
    assign line_drv_o = drive.val;
    assign done_o     = last;

    // R2: every bit opens with a driven low level
    a_r2_opens_low: assert property (@(posedge clk) disable iff (rst)
        accept |=> (line_oe_o && !line_drv_o));

    // R2: a high level is only ever driven, never floated
    a_r2_drv_needs_oe: assert property (@(posedge clk) disable iff (rst)
        line_drv_o |-> line_oe_o);

    // R3 / R4: the speedup drive lasts a single cycle
    a_r3_one_cycle_high: assert property (@(posedge clk) disable iff (rst)
        line_drv_o |=> !line_drv_o);

    // R5: receive bits never drive high
    a_r5_rx_no_high: assert property (@(posedge clk) disable iff (rst)
        (active && kind == KIND_RX) |-> !line_drv_o);

endmodule

// File: tb/tb_dbg_host_bit.sv
module tb_dbg_host_bit;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic rx_mode_i = 1'b0;
    logic tx_bit_i = 1'b0;
    logic line_i = 1'b1;
    logic line_oe_o, line_drv_o, done_o, rx_bit_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dbg_host_bit dut (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .rx_mode_i  (rx_mode_i),
        .tx_bit_i   (tx_bit_i),
        .line_i     (line_i),
        .line_oe_o  (line_oe_o),
        .line_drv_o (line_drv_o),
        .done_o     (done_o),
        .rx_bit_o   (rx_bit_o)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Runs one bit. If cont is 1, the call starts at the negedge of the
    // previous bit's cycle 15, which makes the new start a back-to-back one (R9).
    task automatic run_bit(input logic rx, input logic txb, input logic smp,
                           input logic noise, input logic cont);
        int low;
        string req;
        if (!cont) @(negedge clk);
        start_i = 1'b1; rx_mode_i = rx; tx_bit_i = txb;
        line_i = ~smp;
        @(posedge clk);
        low = rx ? 2 : (txb ? 4 : 13);
        req = rx ? "R5" : (txb ? "R3" : "R4");
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            if (noise && k < 15) begin
                start_i = 1'b1; rx_mode_i = ~rx_mode_i; tx_bit_i = ~tx_bit_i;
            end else begin
                start_i = 1'b0;
            end
            line_i = (k == 10) ? smp : ~smp;
            if (k == 0) check("R2", "opening low oe", line_oe_o, 1'b1);
            check(noise ? "R8_R10" : req, $sformatf("oe cycle %0d", k), line_oe_o,
                  (k < low) || (!rx && k == low));
            check(noise ? "R8_R10" : req, $sformatf("drv cycle %0d", k), line_drv_o,
                  !rx && k == low);
            check(cont ? "R9" : "R7", $sformatf("done cycle %0d", k), done_o, k == 15);
            if (k == 15) check("R6", "sampled bit at done", rx_bit_o, smp);
            else if (k >= 11) check("R6", "sample held", rx_bit_o, smp);
        end
    endtask

    task automatic check_idle(input string req, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(req, "idle oe", line_oe_o, 1'b0);
            check(req, "idle done", done_o, 1'b0);
        end
    endtask

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1", "reset oe", line_oe_o, 1'b0);
        check("R1", "reset drv", line_drv_o, 1'b0);
        check("R1", "reset done", done_o, 1'b0);
        check("R1", "reset rx_bit", rx_bit_o, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "after reset oe", line_oe_o, 1'b0);
        check("R1", "after reset rx_bit", rx_bit_o, 1'b0);

        // Sweep: every kind with both sampled levels
        for (int m = 0; m < 3; m++) begin
            for (int s = 0; s < 2; s++) begin
                run_bit(m == 2, m == 1, s[0], 1'b0, 1'b0);
                check_idle("R2", 2);
            end
        end

        // Mid-bit starts and input flips ignored
        for (int m = 0; m < 3; m++) begin
            run_bit(m == 2, m == 1, m[0], 1'b1, 1'b0);
            check_idle("R8", 3);
        end

        // Back-to-back chain through all kinds
        run_bit(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        run_bit(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        run_bit(1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        run_bit(1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
        check_idle("R9", 2);
        check("R6", "value held after bit", rx_bit_o, 1'b1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule